// File: doc/BRIEF.md
# PWM Action Qualifier

This block turns timing strobes from a time-base counter into two registered PWM pin levels, A and B. Each clock the counter side may pulse any mix of six strobes: count at zero, count at period, count equal to compare A, count equal to compare B, and two generic trigger inputs. A count-direction input tells whether the counter is rising or falling. For each output, every strobe selects a 2-bit action: leave the pin alone, drive it low, drive it high, or invert it. The compare and trigger strobes have separate actions for the rising and falling directions.

When several strobes arrive in the same cycle, a fixed priority picks the one action applied to each output. Software writes the action settings through a small register port into a shadow copy. The whole shadow set is copied into the working set when the zero strobe fires, so a change never lands partway through a PWM period.

Top module: `aq_pwm_qualifier`

## Requirements
- R1: While and after reset, both `pwm_a` and `pwm_b` are low, and every action field reads back as zero.
- R2: Action codes are 2'b00 hold, 2'b01 drive low, 2'b10 drive high and 2'b11 invert. The pin takes its new level on the clock edge that samples the strobe.
- R3: The zero and period strobes each have one field per output. The compare-A, compare-B, trigger-1 and trigger-2 strobes use their up field when `cnt_up` is 1 and their down field when `cnt_up` is 0.
- R4: `cfg_addr`=0 selects output A's settings and `cfg_addr`=1 selects output B's. The 20-bit field word packs two bits per field, listed from the least significant bit upward: zero [1:0], period [3:2], cmpA-up [5:4], cmpA-down [7:6], cmpB-up [9:8], cmpB-down [11:10], trig1-up [13:12], trig1-down [15:14], trig2-up [17:16], trig2-down [19:18]. `cfg_rdata` returns the shadow word of the addressed output, with bits 31:20 reading zero. Each output acts only on its own settings.
- R5: When several strobes occur together, the highest-priority present strobe whose selected action is not hold decides. The order from highest to lowest is trigger 1, trigger 2, compare B, compare A, period, zero.
- R6: A write changes only the shadow copy. The working copy takes the shadow value on each edge where `ev_zero` is high. Strobes in that same cycle still use the old working copy, and a write in that same cycle lands in the shadow only after the copy has been taken.
- R7: A cycle with no strobe, or with only strobes whose selected action is hold, leaves both pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_up | input | 1 | Counter direction, 1 = counting up |
| ev_zero | input | 1 | Counter at zero strobe |
| ev_period | input | 1 | Counter at period strobe |
| ev_cmpa | input | 1 | Counter equals compare A strobe |
| ev_cmpb | input | 1 | Counter equals compare B strobe |
| ev_trig1 | input | 1 | Generic trigger 1 strobe |
| ev_trig2 | input | 1 | Generic trigger 2 strobe |
| cfg_we | input | 1 | Shadow write enable |
| cfg_addr | input | 1 | Output select for write and read |
| cfg_wdata | input | 32 | Write data, bits 19:0 used |
| cfg_rdata | output | 32 | Shadow word of the addressed output |
| pwm_a | output | 1 | Output A pin level |
| pwm_b | output | 1 | Output B pin level |

## Verification
The hardest case to reach is a cycle where a shadow write, a zero strobe that copies the shadow, and higher-priority strobes all coincide. In that cycle the applied action comes from the old working set, the copied value is the shadow as it was before the write, and the write then lands. The bench gets there with a long pseudo-random run in which writes, strobe sets and direction change every cycle. A bench-side model of shadow, working set and pins, written as an overwrite chain rather than a priority scan, predicts every pin level. A directed sweep before that sets each field in turn to each code in both directions, with the other output held at hold.

// File: rtl/aq_pkg.sv
package aq_pkg;

  typedef enum logic [1:0] {
    AQ_HOLD = 2'b00,
    AQ_LOW  = 2'b01,
    AQ_HIGH = 2'b10,
    AQ_FLIP = 2'b11
  } aq_act_e;

  localparam int AQ_FIELDS = 10;
  localparam int AQ_CFG_W  = 2 * AQ_FIELDS;
  localparam int AQ_SRCS   = 6;

  localparam int FLD_ZERO  = 0;
  localparam int FLD_PRD   = 1;
  localparam int FLD_CA_UP = 2;
  localparam int FLD_CA_DN = 3;
  localparam int FLD_CB_UP = 4;
  localparam int FLD_CB_DN = 5;
  localparam int FLD_T1_UP = 6;
  localparam int FLD_T1_DN = 7;
  localparam int FLD_T2_UP = 8;
  localparam int FLD_T2_DN = 9;

  typedef struct packed {
    logic trig1;
    logic trig2;
    logic cmpb;
    logic cmpa;
    logic prd;
    logic zero;
  } aq_evt_t;

  function automatic aq_act_e pick_field(input logic [AQ_CFG_W-1:0] cfg, input int idx);
    return aq_act_e'(cfg[2*idx +: 2]);
  endfunction

  function automatic logic apply_act(input aq_act_e act, input logic cur);
    logic nxt;
    case (act)
      AQ_LOW:  nxt = 1'b0;
      AQ_HIGH: nxt = 1'b1;
      AQ_FLIP: nxt = ~cur;
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/aq_cfg_regs.sv
module aq_cfg_regs #(
  parameter int NUM_OUT = 2,
  parameter int CFG_W   = aq_pkg::AQ_CFG_W,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  input  logic                          load,
  output logic [NUM_OUT-1:0][CFG_W-1:0] active
);

  localparam int PAD_W = DATA_W - CFG_W;

  logic [NUM_OUT-1:0][CFG_W-1:0] shadow;

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic sel_w;
    assign sel_w = wr_en && (addr == ADDR_W'(o));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[o] <= '0;
        active[o] <= '0;
      end else begin
        if (load)  active[o] <= shadow[o];
        if (sel_w) shadow[o] <= wdata[CFG_W-1:0];
      end
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(active[o])); // R6
    AST_ACTIVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (active[o] == $past(shadow[o]))); // R6
  end

  always_comb begin
    rdata = '0;
    for (int o = 0; o < NUM_OUT; o++) begin
      if (addr == ADDR_W'(o)) rdata = {{PAD_W{1'b0}}, shadow[o]};
    end
  end

endmodule

// File: rtl/aq_event_resolve.sv
module aq_event_resolve
  import aq_pkg::*;
#(
  parameter int CFG_W = AQ_CFG_W,
  parameter int NSRC  = AQ_SRCS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg,
  input  aq_evt_t          evt,
  input  logic             cnt_up,
  output aq_act_e          win_act,
  output logic [NSRC-1:0]  win_sel
);

  aq_act_e        cand [NSRC];
  logic [NSRC-1:0] live;

  // candidate 0 has the highest priority
  always_comb begin
    cand[0] = pick_field(cfg, cnt_up ? FLD_T1_UP : FLD_T1_DN);
    cand[1] = pick_field(cfg, cnt_up ? FLD_T2_UP : FLD_T2_DN);
    cand[2] = pick_field(cfg, cnt_up ? FLD_CB_UP : FLD_CB_DN);
    cand[3] = pick_field(cfg, cnt_up ? FLD_CA_UP : FLD_CA_DN);
    cand[4] = pick_field(cfg, FLD_PRD);
    cand[5] = pick_field(cfg, FLD_ZERO);
  end

  assign live = {evt.zero, evt.prd, evt.cmpa, evt.cmpb, evt.trig2, evt.trig1};

  always_comb begin
    logic taken;
    taken   = 1'b0;
    win_sel = '0;
    win_act = AQ_HOLD;
    for (int i = 0; i < NSRC; i++) begin
      if (!taken && live[i] && (cand[i] != AQ_HOLD)) begin
        taken      = 1'b1;
        win_sel[i] = 1'b1;
        win_act    = cand[i];
      end
    end
  end

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (win_act == AQ_HOLD)); // R7
  AST_SEL_IS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_sel & ~live) == '0)); // R5

endmodule

// File: rtl/aq_pin_stage.sv
module aq_pin_stage
  import aq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  aq_act_e act,
  output logic    pin
);

  always_ff @(posedge clk) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= apply_act(act, pin);
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_HOLD) |=> $stable(pin)); // R7
  AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_LOW) |=> !pin); // R2
  AST_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_HIGH) |=> pin); // R2
  AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (act == AQ_FLIP) |=> (pin != $past(pin))); // R2

endmodule

// File: rtl/aq_pwm_qualifier.sv
module aq_pwm_qualifier
  import aq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_up,
  input  logic              ev_zero,
  input  logic              ev_period,
  input  logic              ev_cmpa,
  input  logic              ev_cmpb,
  input  logic              ev_trig1,
  input  logic              ev_trig2,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int NUM_OUT = 2;

  aq_evt_t                          evt;
  logic [NUM_OUT-1:0][AQ_CFG_W-1:0] active_cfg;
  aq_act_e                          win_act [NUM_OUT];
  logic [NUM_OUT-1:0][AQ_SRCS-1:0]  win_sel;
  logic [NUM_OUT-1:0]               pins;

  assign evt = '{trig1: ev_trig1, trig2: ev_trig2, cmpb: ev_cmpb,
                 cmpa: ev_cmpa, prd: ev_period, zero: ev_zero};

  aq_cfg_regs #(
    .NUM_OUT (NUM_OUT),
    .CFG_W   (AQ_CFG_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .load   (ev_zero),
    .active (active_cfg)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_chan
    aq_event_resolve #(
      .CFG_W (AQ_CFG_W),
      .NSRC  (AQ_SRCS)
    ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (active_cfg[o]),
      .evt     (evt),
      .cnt_up  (cnt_up),
      .win_act (win_act[o]),
      .win_sel (win_sel[o])
    );

    aq_pin_stage u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (win_act[o]),
      .pin   (pins[o])
    );
  end

  assign pwm_a = pins[0];
  assign pwm_b = pins[1];

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> (!pwm_a && !pwm_b)); // R1

endmodule

// File: tb/sim_aq_pwm_qualifier.sv
`timescale 1ns/100ps
module sim_aq_pwm_qualifier;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_up = 1'b1;
  logic        ev_zero = 1'b0, ev_period = 1'b0, ev_cmpa = 1'b0;
  logic        ev_cmpb = 1'b0, ev_trig1 = 1'b0, ev_trig2 = 1'b0;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pwm_a, pwm_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [19:0] m_shd [2];
  logic [19:0] m_act [2];
  logic        m_pin [2];

  always #2.5 clk = ~clk;

  aq_pwm_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .cnt_up(cnt_up),
    .ev_zero(ev_zero), .ev_period(ev_period), .ev_cmpa(ev_cmpa),
    .ev_cmpb(ev_cmpb), .ev_trig1(ev_trig1), .ev_trig2(ev_trig2),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  function automatic logic [1:0] fld(input logic [19:0] c, input int i);
    return c[2*i +: 2];
  endfunction

  // ev bits: [0] zero [1] period [2] cmpa [3] cmpb [4] trig1 [5] trig2
  // later overwrites win: lowest priority first
  function automatic logic [1:0] b_resolve(input logic [19:0] c, input logic [5:0] ev, input logic up);
    logic [1:0] a;
    a = 2'b00;
    if (ev[0] && fld(c, 0) != 0) a = fld(c, 0);
    if (ev[1] && fld(c, 1) != 0) a = fld(c, 1);
    if (ev[2] && fld(c, up ? 2 : 3) != 0) a = fld(c, up ? 2 : 3);
    if (ev[3] && fld(c, up ? 4 : 5) != 0) a = fld(c, up ? 4 : 5);
    if (ev[5] && fld(c, up ? 8 : 9) != 0) a = fld(c, up ? 8 : 9);
    if (ev[4] && fld(c, up ? 6 : 7) != 0) a = fld(c, up ? 6 : 7);
    return a;
  endfunction

  function automatic logic b_apply(input logic [1:0] a, input logic cur);
    if (a == 2'b01) return 1'b0;
    if (a == 2'b10) return 1'b1;
    if (a == 2'b11) return !cur;
    return cur;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: drive at negedge, update model, wait for edge, return at next negedge
  task automatic tick(input logic [5:0] ev, input logic up, input logic we,
                      input logic ad, input logic [31:0] wd);
    ev_zero = ev[0]; ev_period = ev[1]; ev_cmpa = ev[2];
    ev_cmpb = ev[3]; ev_trig1 = ev[4]; ev_trig2 = ev[5];
    cnt_up = up; cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
    if (rst_n) begin
      for (int o = 0; o < 2; o++) begin
        m_pin[o] = b_apply(b_resolve(m_act[o], ev, up), m_pin[o]);
        if (ev[0]) m_act[o] = m_shd[o];
      end
      if (we) m_shd[ad] = wd[19:0];
    end
    @(posedge clk);
    @(negedge clk);
    ev_zero = 0; ev_period = 0; ev_cmpa = 0; ev_cmpb = 0;
    ev_trig1 = 0; ev_trig2 = 0; cfg_we = 0;
  endtask

  task automatic chk_pins(input string tag);
    chk(tag, "pwm_a", {31'b0, pwm_a}, {31'b0, m_pin[0]});
    chk(tag, "pwm_b", {31'b0, pwm_b}, {31'b0, m_pin[1]});
  endtask

  function automatic logic [5:0] ev_of_field(input int f);
    case (f)
      0: return 6'b000001;
      1: return 6'b000010;
      2, 3: return 6'b000100;
      4, 5: return 6'b001000;
      6, 7: return 6'b010000;
      default: return 6'b100000;
    endcase
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int o = 0; o < 2; o++) begin
      m_shd[o] = '0; m_act[o] = '0; m_pin[o] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R1", "pwm_a in reset", {31'b0, pwm_a}, 32'h0);
    chk("R1", "pwm_b in reset", {31'b0, pwm_b}, 32'h0);
    rst_n = 1'b1;
    tick(6'b111111, 1'b1, 1'b0, 1'b0, 32'h0);
    chk_pins("R1");
    cfg_addr = 1'b0; #0.1;
    chk("R1", "rdata A", cfg_rdata, 32'h0);
    cfg_addr = 1'b1; #0.1;
    chk("R1", "rdata B", cfg_rdata, 32'h0);

    // R4 readback of the shadow word, upper bits zero
    tick(6'b0, 1'b1, 1'b1, 1'b0, 32'hFFFA_5A5A);
    cfg_addr = 1'b0; #0.1;
    chk("R4", "rdata A", cfg_rdata, 32'h000A_5A5A);
    tick(6'b0, 1'b1, 1'b1, 1'b1, 32'h0003_C3C3);
    cfg_addr = 1'b1; #0.1;
    chk("R4", "rdata B", cfg_rdata, 32'h0003_C3C3);
    chk_pins("R6");

    // R6: written cmpA-up=high not yet active; zero with concurrent write copies old shadow
    tick(6'b0, 1'b1, 1'b1, 1'b0, 32'h20);
    tick(6'b0, 1'b1, 1'b1, 1'b1, 32'h0);
    tick(6'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    tick(6'b000001, 1'b1, 1'b1, 1'b0, 32'h10);
    tick(6'b000001, 1'b1, 1'b0, 1'b0, 32'h0);
    tick(6'b000100, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R6", "pwm_a after cmpa", {31'b0, pwm_a}, 32'h0);
    chk_pins("R6");

    // R7: all settings hold, every strobe fires
    tick(6'b0, 1'b1, 1'b1, 1'b0, 32'h0);
    tick(6'b0, 1'b1, 1'b1, 1'b1, 32'h0);
    tick(6'b000001, 1'b1, 1'b0, 1'b0, 32'h0);
    tick(6'b000001, 1'b1, 1'b0, 1'b0, 32'h0);
    for (int k = 0; k < 64; k++) begin
      logic prev_a, prev_b;
      prev_a = pwm_a; prev_b = pwm_b;
      tick(k[5:0], k[0], 1'b0, 1'b0, 32'h0);
      chk("R7", "pwm_a held", {31'b0, pwm_a}, {31'b0, prev_a});
      chk("R7", "pwm_b held", {31'b0, pwm_b}, {31'b0, prev_b});
    end

    // R5 directed: cmpA-up=high, cmpB-up=low, both fire -> low; add trig1-up=high -> high
    tick(6'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0160);
    tick(6'b000001, 1'b1, 1'b0, 1'b0, 32'h0);
    tick(6'b000100, 1'b1, 1'b0, 1'b0, 32'h0);
    tick(6'b001100, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R5", "cmpb over cmpa", {31'b0, pwm_a}, 32'h0);
    tick(6'b0, 1'b1, 1'b1, 1'b0, 32'h0000_2160);
    tick(6'b000001, 1'b1, 1'b0, 1'b0, 32'h0);
    tick(6'b111110, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R5", "trig1 over rest", {31'b0, pwm_a}, 32'h1);
    chk_pins("R5");

    // R2/R3/R4 sweep: each field, each code, each direction, one output at a time
    for (int o = 0; o < 2; o++) begin
      for (int f = 0; f < 10; f++) begin
        for (int v = 0; v < 4; v++) begin
          for (int up = 0; up < 2; up++) begin
            logic [31:0] w;
            w = 32'(v) << (2 * f);
            tick(6'b0, up[0], 1'b1, o[0], w);
            tick(6'b0, up[0], 1'b1, !o[0], 32'h0);
            tick(6'b000001, up[0], 1'b0, 1'b0, 32'h0);
            chk_pins("R3");
            tick(ev_of_field(f), up[0], 1'b0, 1'b0, 32'h0);
            chk_pins("R2");
            tick(ev_of_field(f), up[0], 1'b0, 1'b0, 32'h0);
            chk_pins("R4");
          end
        end
      end
    end

    // pseudo-random run: strobes, direction and writes change every cycle
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] wd;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wd = {lfsr, lfsr[7:0], lfsr[15:8]} ^ 32'(n * 40503);
      tick(lfsr[5:0] & {5'b11111, lfsr[9] | lfsr[8]}, lfsr[6],
           lfsr[7] & lfsr[11], lfsr[12], wd);
      chk_pins("R5");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule